// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. One global history register records the outcomes of the most recently resolved branches. It is shared by every branch. One table of two-bit saturating counters is also shared by every branch. The history and the low bits of the branch address are combined by bitwise XOR, and the result picks one counter. The counter's upper bit is the guess. The fetch stage presents an address and, in the same cycle, receives the guess and the index that produced it. It carries that index down the pipeline with the branch.

When the branch resolves, the back end returns the carried index together with the real outcome. That counter steps toward the outcome, and the outcome is shifted into the history. After a misprediction, the back end can overwrite the history with a checkpointed value shifted by the correct outcome. This discards the history bits that wrong-path updates left behind. Storage is HIST_W history bits plus 2^HIST_W counters of two bits each.

Top module: `gxp_predictor`

## Requirements
- R1: After synchronous reset the history is all zeros and every counter holds 2'b01 (weakly not taken). Every lookup therefore predicts not taken, and its index equals the address's low HIST_W bits.
- R2: The lookup index `pred_index` is combinational and equals `lk_addr[HIST_W-1:0]` XOR the current history.
- R3: `pred_taken` equals bit 1 of the counter selected by `pred_index`, with 1 meaning taken.
- R4: An update with `upd_taken`=1 raises the counter at `upd_index` by one, saturating at 2'b11.
- R5: An update with `upd_taken`=0 lowers the counter at `upd_index` by one, saturating at 2'b00.
- R6: Each update without a restore shifts the history left by one and places `upd_taken` in bit 0.
- R7: A restore sets the history to `{hr_value[HIST_W-2:0], hr_taken}`. When an update arrives in the same cycle, the restore wins for the history, but the update still trains its counter.
- R8: An update changes only the counter it names. When neither an update nor a restore is present, neither the history nor any counter changes.
- R9: Lookup reads the state as it was before the clock edge. An update takes effect for lookups from the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | ADDR_W | Branch address for lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | HIST_W | Counter index used by this lookup |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_index | input | HIST_W | Index returned from the lookup of the resolving branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| hr_valid | input | 1 | History restore strobe |
| hr_value | input | HIST_W | Checkpointed history to restore |
| hr_taken | input | 1 | Correct outcome appended on restore |

## Verification
The assertions assume that `lk_addr` and the update and restore inputs are driven to known values in every cycle once reset is released. They place no constraint on ordering, so an update and a restore may coincide, and updates may name any index, not only one recently looked up. The stimulus holds every input at zero through reset and then drives all of them on every cycle. Random phases deliberately include coincident update and restore and indices unrelated to the current lookup. Directed phases choose addresses that cancel the moving history, so one counter can be driven repeatedly into both saturation limits.

// File: rtl/gxp_pkg.sv
package gxp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_INIT = CTR_WNT;

    typedef struct packed {
        logic valid;
        logic taken;
    } outcome_t;

    function automatic ctr_e ctr_train(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_dir(input ctr_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/gxp_history.sv
module gxp_history
    import gxp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  outcome_t          shift_in,
    input  logic              restore,
    input  logic [HIST_W-1:0] restore_val,
    input  logic              restore_taken,
    output logic [HIST_W-1:0] hist_q
);

    logic [HIST_W-1:0] hist_d;

    always_comb begin
        hist_d = hist_q;
        if (restore)
            hist_d = {restore_val[HIST_W-2:0], restore_taken};
        else if (shift_in.valid)
            hist_d = {hist_q[HIST_W-2:0], shift_in.taken};
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end

    a_r1_hist_clear: assert property (@(posedge clk) rst |=> hist_q == '0);

    a_r6_shift_in: assert property (@(posedge clk) disable iff (rst)
        (shift_in.valid && !restore) |=> hist_q[0] == $past(shift_in.taken));

    a_r7_restore_wins: assert property (@(posedge clk) disable iff (rst)
        restore |=> hist_q[HIST_W-1:1] == $past(restore_val[HIST_W-2:0]));

    a_r8_hist_idle: assert property (@(posedge clk) disable iff (rst)
        (!restore && !shift_in.valid) |=> $stable(hist_q));

endmodule

// File: rtl/gxp_hash.sv
module gxp_hash #(
    parameter int HIST_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [HIST_W-1:0] hist,
    output logic [HIST_W-1:0] index
);

    for (genvar b = 0; b < HIST_W; b++) begin : g_bit
        assign index[b] = addr[b] ^ hist[b];
    end

endmodule

// File: rtl/gxp_ctr_table.sv
module gxp_ctr_table
    import gxp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] rd_idx,
    output ctr_e              rd_ctr,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken
);

    localparam int DEPTH = 1 << HIST_W;

    ctr_e ctr_q [DEPTH];

    assign rd_ctr = ctr_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_train(ctr_q[wr_idx], wr_taken);
        end
    end

    a_r4_ceiling: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && ctr_q[wr_idx] == CTR_ST)
        |=> ctr_q[$past(wr_idx)] == CTR_ST);

    a_r5_floor: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_SNT)
        |=> ctr_q[$past(wr_idx)] == CTR_SNT);

    a_r4_rise: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && ctr_q[wr_idx] == CTR_WNT)
        |=> ctr_q[$past(wr_idx)] == CTR_WT);

    a_r5_fall: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_WT)
        |=> ctr_q[$past(wr_idx)] == CTR_WNT);

endmodule

// File: rtl/gxp_predictor.sv
module gxp_predictor
    import gxp_pkg::*;
#(
    parameter int HIST_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_index,
    input  logic              upd_valid,
    input  logic [HIST_W-1:0] upd_index,
    input  logic              upd_taken,
    input  logic              hr_valid,
    input  logic [HIST_W-1:0] hr_value,
    input  logic              hr_taken
);

    logic [HIST_W-1:0] hist;
    ctr_e              rd_ctr;
    outcome_t          resolved;

    assign resolved = '{valid: upd_valid, taken: upd_taken};

    gxp_history #(.HIST_W(HIST_W)) u_hist (
        .clk           (clk),
        .rst           (rst),
        .shift_in      (resolved),
        .restore       (hr_valid),
        .restore_val   (hr_value),
        .restore_taken (hr_taken),
        .hist_q        (hist)
    );

    gxp_hash #(.HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_hash (
        .addr  (lk_addr),
        .hist  (hist),
        .index (pred_index)
    );

    gxp_ctr_table #(.HIST_W(HIST_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (pred_index),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_index),
        .wr_taken (upd_taken)
    );

    assign pred_taken = ctr_dir(rd_ctr);

    a_r2_index_hash: assert property (@(posedge clk) disable iff (rst)
        (pred_index ^ hist) == lk_addr[HIST_W-1:0]);

    a_r1_reset_not_taken: assert property (@(posedge clk) rst |=> !pred_taken);

endmodule

// File: tb/gxp_predictor_tb.sv
`timescale 1ns/1ps
module gxp_predictor_tb;

    localparam int HIST_W = 8;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 1 << HIST_W;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] lk_addr;
    logic              pred_taken;
    logic [HIST_W-1:0] pred_index;
    logic              upd_valid;
    logic [HIST_W-1:0] upd_index;
    logic              upd_taken;
    logic              hr_valid;
    logic [HIST_W-1:0] hr_value;
    logic              hr_taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [HIST_W-1:0] hist_m;
    logic [1:0]        tbl_m [DEPTH];

    always #4 clk = ~clk;

    gxp_predictor #(.HIST_W(HIST_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .lk_addr(lk_addr), .pred_taken(pred_taken),
        .pred_index(pred_index), .upd_valid(upd_valid), .upd_index(upd_index),
        .upd_taken(upd_taken), .hr_valid(hr_valid), .hr_value(hr_value),
        .hr_taken(hr_taken)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] m_train(input logic [1:0] c, input logic t);
        if (t)  return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    // One cycle: drive at negedge, check lookup outputs against the model,
    // then advance the model at the posedge.
    task automatic cyc(input string req, input logic [ADDR_W-1:0] a,
                       input logic uv, input logic [HIST_W-1:0] ui, input logic ut,
                       input logic rv, input logic [HIST_W-1:0] rval, input logic rt);
        logic [HIST_W-1:0] ei;
        @(negedge clk);
        lk_addr = a; upd_valid = uv; upd_index = ui; upd_taken = ut;
        hr_valid = rv; hr_value = rval; hr_taken = rt;
        #1;
        ei = a[HIST_W-1:0] ^ hist_m;
        chk({req, " R2 index"}, 32'(pred_index), 32'(ei));
        chk({req, " R3 direction"}, 32'(pred_taken), 32'(tbl_m[ei][1]));
        @(posedge clk);
        if (uv) tbl_m[ui] = m_train(tbl_m[ui], ut);
        if (rv)      hist_m = {rval[HIST_W-2:0], rt};
        else if (uv) hist_m = {hist_m[HIST_W-2:0], ut};
    endtask

    // Train counter idx: lookup aimed at idx despite the moving history.
    task automatic train(input string req, input logic [HIST_W-1:0] idx, input logic t);
        cyc(req, ADDR_W'(idx ^ hist_m), 1'b1, idx, t, 1'b0, '0, 1'b0);
    endtask

    task automatic probe(input string req, input logic [HIST_W-1:0] idx);
        cyc(req, ADDR_W'(idx ^ hist_m), 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; lk_addr = '0; upd_valid = 0; upd_index = '0; upd_taken = 0;
        hr_valid = 0; hr_value = '0; hr_taken = 0;
        hist_m = '0;
        for (int i = 0; i < DEPTH; i++) tbl_m[i] = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state seen at the ports
        @(negedge clk); lk_addr = 16'hA5C3; #1;
        chk("R1 reset index", 32'(pred_index), 32'h00C3);
        chk("R1 reset predicts not taken", 32'(pred_taken), 0);
        @(negedge clk); lk_addr = 16'h00FF; #1;
        chk("R1 reset index high", 32'(pred_index), 32'h00FF);
        chk("R1 reset predicts not taken high", 32'(pred_taken), 0);

        // R4: ceiling at 11, then one not-taken still predicts taken
        for (int i = 0; i < 5; i++) train("R4 raise", 8'h35, 1'b1);
        train("R4 ceiling", 8'h35, 1'b0);
        probe("R4 after ceiling", 8'h35);
        chk("R4 saturated counter survives one miss", 32'(pred_taken), 1);

        // R5: floor at 00, then one taken still predicts not taken
        for (int i = 0; i < 5; i++) train("R5 lower", 8'h9A, 1'b0);
        train("R5 floor", 8'h9A, 1'b1);
        probe("R5 after floor", 8'h9A);
        chk("R5 floored counter survives one hit", 32'(pred_taken), 0);

        // R6: history shifts taken into bit 0
        cyc("R6 restore zero", '0, 1'b0, '0, 1'b0, 1'b1, '0, 1'b0);
        cyc("R6 shift", '0, 1'b1, 8'h01, 1'b1, 1'b0, '0, 1'b0);
        cyc("R6 shift", '0, 1'b1, 8'h02, 1'b0, 1'b0, '0, 1'b0);
        @(negedge clk); lk_addr = '0; upd_valid = 0; hr_valid = 0; #1;
        chk("R6 history 0b10 after 1,0", 32'(pred_index), 32'h02);

        // R7: restore with coincident update: restore wins, counter trained
        cyc("R7 coincide", '0, 1'b1, 8'h44, 1'b1, 1'b1, 8'hF0, 1'b1);
        @(negedge clk); lk_addr = '0; upd_valid = 0; hr_valid = 0; #1;
        chk("R7 restored history", 32'(pred_index), 32'hE1);
        probe("R7 counter still trained", 8'h44);
        chk("R7 coincident update trained counter", 32'(pred_taken), 1);

        // R8/R9: idle cycles keep state; same-cycle lookup sees old value
        for (int i = 0; i < 4; i++) probe("R8 idle", 8'h35);
        train("R9 pre", 8'h60, 1'b1);
        @(negedge clk); upd_valid = 0; lk_addr = ADDR_W'(8'h60 ^ hist_m); #1;
        chk("R9 update visible next cycle", 32'(pred_taken), 1);

        // Random: all inputs, coincident update/restore, unrelated indices
        for (int n = 0; n < 4000; n++) begin
            logic [ADDR_W-1:0] a;
            logic uv, ut, rv, rt;
            logic [HIST_W-1:0] ui, rval;
            a    = ADDR_W'($urandom);
            uv   = ($urandom % 3) != 0;
            ut   = ($urandom % 4) != 0;
            ui   = ($urandom % 2) ? (a[HIST_W-1:0] ^ hist_m) : HIST_W'($urandom);
            rv   = ($urandom % 16) == 0;
            rval = HIST_W'($urandom);
            rt   = 1'($urandom);
            cyc("R8 random", a, uv, ui, ut, rv, rval, rt);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule